// File: doc/BRIEF.md
# Strobed Parallel Input Capture Unit

This block takes in a 32-bit parallel input bus. It samples the bus on each rising edge of an external strobe, so no internal sample clock sets the pace. Each sample goes into an on-chip word FIFO. A command pulse latches the configuration and starts a capture session. The configuration sets three things: how many bits of the bus form one sample (32, 16 or 8), whether capture starts at once or waits for a rising edge on an external trigger, and the FIFO fill level at which the external source is told to pause.

Narrow samples are packed little-endian into 32-bit words: the first sample of a word goes in the lowest lane. The acknowledge output goes to the external source. It stays high while a session is open (armed or running) and the FIFO holds fewer words than the pause level. If the source keeps strobing into a full FIFO, each such sample is discarded and a sticky overflow flag is raised. A show-ahead read port drains the FIFO in the same way a bus-master transfer engine would. A stop command ends the session and discards any partly packed word. Words already stored stay readable.

Top module: `strobe_capture`

## Requirements
- R1: After reset, `ext_ack`, `rd_valid`, `fifo_full` and `overflow` are 0 and `fifo_count` is 0.
- R2: In 32-bit mode (`cfg_width` = 0), each rising edge of `ext_strobe` while running writes one word equal to `ext_data`. `fifo_count` shows the word 3 clock cycles after the strobe rises. A strobe held high or a falling strobe writes nothing.
- R3: With `cfg_wait_trig` = 1 at start, strobes are ignored until a rising edge of `ext_trigger` is seen. After that edge they are captured. With `cfg_wait_trig` = 0, capture begins right after `cmd_start`. While idle, strobes are ignored.
- R4: In 16-bit mode (`cfg_width` = 1), two samples form one word. The first sample's bits 15:0 go in word bits 15:0 and the second sample's in bits 31:16. Nothing is written after the first sample alone.
- R5: In 8-bit mode (`cfg_width` = 2), four samples form one word. Sample k's bits 7:0 go in word bits 8k+7:8k, with k counted from 0.
- R6: `ext_ack` is 1 while a session is armed or running and `fifo_count` is below the pause level. It is 0 otherwise. The pause level is latched from `cfg_afull_level` on `cmd_start`, and its reset value is DEPTH-16.
- R7: A strobe edge that arrives while running with a full FIFO leaves the FIFO contents unchanged and sets `overflow`. `overflow` stays set, even across `cmd_stop`, until the next `cmd_start`.
- R8: `cmd_stop` returns the unit to idle and drops `ext_ack`. It discards a partly packed word and keeps the complete words already stored.
- R9: `rd_valid` is 1 whenever the FIFO is not empty. `rd_data` shows the oldest word, and `rd_en` with `rd_valid` removes it, so words leave in the order they were written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_width | input | 2 | Sample width code: 0 = 32-bit, 1 = 16-bit, 2 = 8-bit; latched on start |
| cfg_wait_trig | input | 1 | 1 = arm and wait for trigger; latched on start |
| cfg_afull_level | input | $clog2(DEPTH)+1 | Pause level in words; latched on start |
| cmd_start | input | 1 | One-cycle pulse: open a session, clear overflow, flush packer |
| cmd_stop | input | 1 | One-cycle pulse: close the session, flush packer (wins over start) |
| ext_strobe | input | 1 | Asynchronous sample strobe, rising edge active |
| ext_trigger | input | 1 | Asynchronous start trigger, rising edge active |
| ext_data | input | 32 | Parallel input bus, held stable around the strobe |
| ext_ack | output | 1 | High while the source may send |
| rd_en | input | 1 | Pop the oldest word |
| rd_valid | output | 1 | FIFO not empty |
| rd_data | output | 32 | Oldest stored word |
| fifo_count | output | $clog2(DEPTH)+1 | Words stored |
| fifo_full | output | 1 | FIFO holds DEPTH words |
| overflow | output | 1 | Sticky lost-sample flag |

## Verification
A strobe rise is seen through two synchronizer flops and one history flop, and the packer writes the FIFO without extra staging. A completed word therefore shows up in `fifo_count` on the third clock edge after the strobe rises. A trigger rise takes the unit from armed to running on that same third edge. Commands and pops take effect on the next edge. The bench drives every input at a falling edge and samples one falling edge after the edge on which the result is due. It also checks the latency directly: the count must still be unchanged one falling edge earlier. Each strobe pulse is held high and then low for three cycles, so every pulse makes exactly one edge.

// File: rtl/strobe_capture_pkg.sv
package strobe_capture_pkg;

  localparam int WORD_W = 32;

  typedef enum logic [1:0] {
    SW_32 = 2'd0,
    SW_16 = 2'd1,
    SW_8  = 2'd2
  } sample_width_e;

  typedef enum logic [1:0] {
    CS_IDLE  = 2'd0,
    CS_ARMED = 2'd1,
    CS_RUN   = 2'd2
  } cap_state_e;

  // Index of the lane that completes a word for a given width.
  function automatic logic [1:0] final_lane(input sample_width_e w);
    case (w)
      SW_16:   final_lane = 2'd1;
      SW_8:    final_lane = 2'd3;
      default: final_lane = 2'd0;
    endcase
  endfunction

  // Insert one sample into the word under construction at the given lane.
  function automatic logic [WORD_W-1:0] place_sample(
    input logic [WORD_W-1:0] acc,
    input logic [WORD_W-1:0] sample,
    input logic [1:0]        lane,
    input sample_width_e     w
  );
    logic [WORD_W-1:0] res;
    res = acc;
    case (w)
      SW_16: begin
        if (lane[0]) res[31:16] = sample[15:0];
        else         res[15:0]  = sample[15:0];
      end
      SW_8: begin
        case (lane)
          2'd0:    res[7:0]   = sample[7:0];
          2'd1:    res[15:8]  = sample[7:0];
          2'd2:    res[23:16] = sample[7:0];
          default: res[31:24] = sample[7:0];
        endcase
      end
      default: res = sample;
    endcase
    place_sample = res;
  endfunction

endpackage

// File: rtl/edge_sync.sv
module edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  logic [STAGES:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-1:0], async_in};
  end

  assign rise = chain_q[STAGES-1] & ~chain_q[STAGES];
endmodule

// File: rtl/capture_ctrl.sv
module capture_ctrl
  import strobe_capture_pkg::*;
#(
  parameter int CNT_W      = 7,
  parameter int RESET_LVL  = 48
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_start,
  input  logic             cmd_stop,
  input  logic [1:0]       cfg_width,
  input  logic             cfg_wait_trig,
  input  logic [CNT_W-1:0] cfg_afull_level,
  input  logic             trig_rise,
  input  logic             stb_rise,
  input  logic             fifo_full,
  input  logic [CNT_W-1:0] fifo_count,
  output logic             run,
  output logic             flush,
  output sample_width_e    width_q,
  output logic [CNT_W-1:0] afull_q,
  output logic             overflow,
  output logic             ack
);
  cap_state_e state_q, state_d;
  logic       ovf_q;
  logic       enabled;

  always_comb begin
    state_d = state_q;
    if (cmd_stop)                             state_d = CS_IDLE;
    else if (cmd_start)                       state_d = cfg_wait_trig ? CS_ARMED : CS_RUN;
    else if (state_q == CS_ARMED && trig_rise) state_d = CS_RUN;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CS_IDLE;
      width_q <= SW_32;
      afull_q <= CNT_W'(RESET_LVL);
      ovf_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (cmd_start && !cmd_stop) begin
        width_q <= sample_width_e'(cfg_width);
        afull_q <= cfg_afull_level;
      end
      if (cmd_start)                          ovf_q <= 1'b0;
      else if (run && stb_rise && fifo_full)  ovf_q <= 1'b1;
    end
  end

  assign run      = (state_q == CS_RUN);
  assign enabled  = (state_q != CS_IDLE);
  assign flush    = cmd_start | cmd_stop;
  assign overflow = ovf_q;
  assign ack      = enabled && (fifo_count < afull_q);
endmodule

// File: rtl/lane_packer.sv
module lane_packer
  import strobe_capture_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              flush,
  input  sample_width_e     width,
  input  logic [WORD_W-1:0] sample,
  output logic              wr_en,
  output logic [WORD_W-1:0] wr_word
);
  logic [WORD_W-1:0] acc_q;
  logic [1:0]        lane_q;
  logic              last;

  always_comb begin
    wr_word = place_sample(acc_q, sample, lane_q, width);
    last    = (lane_q == final_lane(width));
    wr_en   = accept && last;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      lane_q <= '0;
    end else if (flush) begin
      acc_q  <= '0;
      lane_q <= '0;
    end else if (accept) begin
      if (last) begin
        acc_q  <= '0;
        lane_q <= '0;
      end else begin
        acc_q  <= wr_word;
        lane_q <= lane_q + 2'd1;
      end
    end
  end
endmodule

// File: rtl/word_fifo.sv
module word_fifo #(
  parameter int DEPTH  = 64,
  parameter int DATA_W = 32,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int CNT_W  = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              empty,
  output logic              full,
  output logic [CNT_W-1:0]  count
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0]  cnt_q;
  logic              push, pop;

  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == CNT_W'(DEPTH));
  assign push  = wr_en && !full;
  assign pop   = rd_en && !empty;

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_q  <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + 1'b1;
      if (pop)  rd_ptr <= rd_ptr + 1'b1;
      case ({push, pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign rd_data = mem[rd_ptr];
  assign count   = cnt_q;
endmodule

// File: rtl/strobe_capture.sv
module strobe_capture
  import strobe_capture_pkg::*;
#(
  parameter int DEPTH        = 64,
  parameter int AFULL_MARGIN = 16,
  parameter int SYNC_STAGES  = 2,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int CNT_W  = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cfg_width,
  input  logic              cfg_wait_trig,
  input  logic [CNT_W-1:0]  cfg_afull_level,
  input  logic              cmd_start,
  input  logic              cmd_stop,
  input  logic              ext_strobe,
  input  logic              ext_trigger,
  input  logic [WORD_W-1:0] ext_data,
  output logic              ext_ack,
  input  logic              rd_en,
  output logic              rd_valid,
  output logic [WORD_W-1:0] rd_data,
  output logic [CNT_W-1:0]  fifo_count,
  output logic              fifo_full,
  output logic              overflow
);
  // Named internal events, observed by the bound checker.
  logic              stb_rise, trig_rise;
  logic              run, flush, accept;
  logic              wr_en, rd_pop, empty;
  logic [WORD_W-1:0] wr_word;
  logic [CNT_W-1:0]  afull_q;
  sample_width_e     width_q;

  edge_sync #(.STAGES(SYNC_STAGES)) u_stb_sync (
    .clk(clk), .rst_n(rst_n), .async_in(ext_strobe), .rise(stb_rise)
  );

  edge_sync #(.STAGES(SYNC_STAGES)) u_trig_sync (
    .clk(clk), .rst_n(rst_n), .async_in(ext_trigger), .rise(trig_rise)
  );

  capture_ctrl #(.CNT_W(CNT_W), .RESET_LVL(DEPTH - AFULL_MARGIN)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cmd_start(cmd_start), .cmd_stop(cmd_stop),
    .cfg_width(cfg_width), .cfg_wait_trig(cfg_wait_trig),
    .cfg_afull_level(cfg_afull_level),
    .trig_rise(trig_rise), .stb_rise(stb_rise),
    .fifo_full(fifo_full), .fifo_count(fifo_count),
    .run(run), .flush(flush), .width_q(width_q), .afull_q(afull_q),
    .overflow(overflow), .ack(ext_ack)
  );

  assign accept = stb_rise && run && !fifo_full && !flush;

  lane_packer u_pack (
    .clk(clk), .rst_n(rst_n), .accept(accept), .flush(flush),
    .width(width_q), .sample(ext_data), .wr_en(wr_en), .wr_word(wr_word)
  );

  assign rd_pop = rd_en && !empty;

  word_fifo #(.DEPTH(DEPTH), .DATA_W(WORD_W)) u_fifo (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_word),
    .rd_en(rd_en), .rd_data(rd_data), .empty(empty), .full(fifo_full),
    .count(fifo_count)
  );

  assign rd_valid = !empty;
endmodule

// File: rtl/strobe_capture_checker.sv
module strobe_capture_checker #(
  parameter int DEPTH = 64,
  parameter int CNT_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_start,
  input logic             cmd_stop,
  input logic             stb_rise,
  input logic             trig_rise,
  input logic             run,
  input logic             wr_en,
  input logic             rd_pop,
  input logic             fifo_full,
  input logic [CNT_W-1:0] fifo_count,
  input logic [CNT_W-1:0] afull_q,
  input logic             ext_ack,
  input logic             overflow
);
  a_r2_write_needs_edge: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (stb_rise && run));

  a_r3_run_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> ($past(cmd_start) || $past(trig_rise)));

  a_r6_ack_low_at_level: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_count >= afull_q) |-> !ext_ack);

  a_r8_stop_drops_ack: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stop |=> !ext_ack);

  a_r7_full_persists: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_full && !rd_pop) |=> fifo_full);

  a_r7_overflow_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (run && stb_rise && fifo_full && !cmd_start) |=> overflow);

  a_r7_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !cmd_start) |=> overflow);

  a_r9_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_count <= CNT_W'(DEPTH));
endmodule

bind strobe_capture strobe_capture_checker #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_checker (
  .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_stop(cmd_stop),
  .stb_rise(stb_rise), .trig_rise(trig_rise), .run(run), .wr_en(wr_en),
  .rd_pop(rd_pop), .fifo_full(fifo_full), .fifo_count(fifo_count),
  .afull_q(afull_q), .ext_ack(ext_ack), .overflow(overflow)
);

// File: tb/strobe_capture_bench.sv
module strobe_capture_bench;
  localparam int DEPTH = 64;
  localparam int CNT_W = $clog2(DEPTH) + 1;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [1:0]       cfg_width = 2'd0;
  logic             cfg_wait_trig = 1'b0;
  logic [CNT_W-1:0] cfg_afull_level = '0;
  logic             cmd_start = 1'b0, cmd_stop = 1'b0;
  logic             ext_strobe = 1'b0, ext_trigger = 1'b0;
  logic [31:0]      ext_data = '0;
  logic             ext_ack, rd_en = 1'b0, rd_valid, fifo_full, overflow;
  logic [31:0]      rd_data;
  logic [CNT_W-1:0] fifo_count;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  strobe_capture #(.DEPTH(DEPTH)) u_strobe_capture (
    .clk(clk), .rst_n(rst_n), .cfg_width(cfg_width), .cfg_wait_trig(cfg_wait_trig),
    .cfg_afull_level(cfg_afull_level), .cmd_start(cmd_start), .cmd_stop(cmd_stop),
    .ext_strobe(ext_strobe), .ext_trigger(ext_trigger), .ext_data(ext_data),
    .ext_ack(ext_ack), .rd_en(rd_en), .rd_valid(rd_valid), .rd_data(rd_data),
    .fifo_count(fifo_count), .fifo_full(fifo_full), .overflow(overflow)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wait_neg(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic strobe(input logic [31:0] d);
    @(negedge clk);
    ext_data   = d;
    ext_strobe = 1'b1;
    wait_neg(3);
    ext_strobe = 1'b0;
    wait_neg(3);
  endtask

  task automatic trigger();
    @(negedge clk);
    ext_trigger = 1'b1;
    wait_neg(3);
    ext_trigger = 1'b0;
    wait_neg(3);
  endtask

  task automatic start(input logic [1:0] w, input logic wt, input int lvl);
    @(negedge clk);
    cfg_width       = w;
    cfg_wait_trig   = wt;
    cfg_afull_level = CNT_W'(lvl);
    cmd_start       = 1'b1;
    @(negedge clk);
    cmd_start = 1'b0;
  endtask

  task automatic stop();
    @(negedge clk);
    cmd_stop = 1'b1;
    @(negedge clk);
    cmd_stop = 1'b0;
  endtask

  task automatic pop_expect(input string tag, input logic [31:0] exp);
    chk({tag, " rd_valid"}, 32'(rd_valid), 32'd1);
    chk({tag, " rd_data"}, rd_data, exp);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 ack", 32'(ext_ack), 32'd0);
    chk("R1 rd_valid", 32'(rd_valid), 32'd0);
    chk("R1 full", 32'(fifo_full), 32'd0);
    chk("R1 overflow", 32'(overflow), 32'd0);
    chk("R1 count", 32'(fifo_count), 32'd0);
  endtask

  task automatic t_word32();
    start(2'd0, 1'b0, 48);
    chk("R6 ack running", 32'(ext_ack), 32'd1);
    @(negedge clk);
    ext_data   = 32'hA5A5_0001;
    ext_strobe = 1'b1;
    wait_neg(2);
    chk("R2 count before 3 cycles", 32'(fifo_count), 32'd0);
    @(negedge clk);
    chk("R2 count at 3 cycles", 32'(fifo_count), 32'd1);
    wait_neg(3);
    chk("R2 held strobe no extra write", 32'(fifo_count), 32'd1);
    ext_strobe = 1'b0;
    wait_neg(4);
    chk("R2 falling strobe no write", 32'(fifo_count), 32'd1);
    strobe(32'h1234_5678);
    chk("R2 second word count", 32'(fifo_count), 32'd2);
    pop_expect("R9 first word", 32'hA5A5_0001);
    pop_expect("R2 second word", 32'h1234_5678);
    chk("R9 empty after drain", 32'(rd_valid), 32'd0);
    stop();
  endtask

  task automatic t_trigger();
    strobe(32'h0BAD_0000);
    chk("R3 idle strobe ignored", 32'(fifo_count), 32'd0);
    start(2'd0, 1'b1, 48);
    chk("R6 ack while armed", 32'(ext_ack), 32'd1);
    strobe(32'h0BAD_0001);
    chk("R3 armed strobe ignored", 32'(fifo_count), 32'd0);
    trigger();
    strobe(32'hCAFE_0003);
    chk("R3 strobe after trigger", 32'(fifo_count), 32'd1);
    pop_expect("R3 triggered word", 32'hCAFE_0003);
    stop();
  endtask

  task automatic t_pack16();
    start(2'd1, 1'b0, 48);
    strobe(32'hAAAA_1111);
    chk("R4 half word not written", 32'(fifo_count), 32'd0);
    strobe(32'hBBBB_2222);
    chk("R4 word written", 32'(fifo_count), 32'd1);
    pop_expect("R4 lanes", 32'h2222_1111);
    stop();
  endtask

  task automatic t_pack8();
    start(2'd2, 1'b0, 48);
    strobe(32'hFFFF_FF11);
    strobe(32'hEEEE_EE22);
    strobe(32'hDDDD_DD33);
    chk("R5 three bytes not written", 32'(fifo_count), 32'd0);
    strobe(32'hCCCC_CC44);
    chk("R5 word written", 32'(fifo_count), 32'd1);
    pop_expect("R5 lanes", 32'h4433_2211);
    stop();
  endtask

  task automatic t_stop_flush();
    start(2'd1, 1'b0, 48);
    strobe(32'h0000_0001);
    strobe(32'h0000_0002);
    strobe(32'h0000_0003);
    stop();
    chk("R8 ack after stop", 32'(ext_ack), 32'd0);
    chk("R8 stored word kept", 32'(fifo_count), 32'd1);
    strobe(32'h0000_0009);
    chk("R3 strobe ignored after stop", 32'(fifo_count), 32'd1);
    start(2'd1, 1'b0, 48);
    strobe(32'h0000_0004);
    strobe(32'h0000_0005);
    pop_expect("R8 old word", 32'h0002_0001);
    pop_expect("R8 partial discarded", 32'h0005_0004);
    stop();
  endtask

  task automatic t_ack_level();
    start(2'd0, 1'b0, 4);
    for (int i = 0; i < 3; i++) strobe(32'h100 + 32'(i));
    chk("R6 ack below level", 32'(ext_ack), 32'd1);
    strobe(32'h103);
    chk("R6 ack at level", 32'(ext_ack), 32'd0);
    pop_expect("R9 level word0", 32'h100);
    chk("R6 ack after pop", 32'(ext_ack), 32'd1);
    pop_expect("R9 level word1", 32'h101);
    pop_expect("R9 level word2", 32'h102);
    pop_expect("R9 level word3", 32'h103);
    stop();
  endtask

  task automatic t_overflow();
    start(2'd0, 1'b0, DEPTH - 16);
    for (int i = 0; i < DEPTH - 17; i++) strobe(32'hC000_0000 + 32'(i));
    chk("R6 ack one below threshold", 32'(ext_ack), 32'd1);
    strobe(32'hC000_0000 + 32'(DEPTH - 17));
    chk("R6 ack at threshold", 32'(ext_ack), 32'd0);
    for (int i = DEPTH - 16; i < DEPTH; i++) strobe(32'hC000_0000 + 32'(i));
    chk("R7 full", 32'(fifo_full), 32'd1);
    chk("R7 no overflow yet", 32'(overflow), 32'd0);
    strobe(32'hDEAD_BEEF);
    chk("R7 count unchanged", 32'(fifo_count), 32'(DEPTH));
    chk("R7 overflow set", 32'(overflow), 32'd1);
    stop();
    chk("R7 overflow survives stop", 32'(overflow), 32'd1);
    start(2'd0, 1'b0, DEPTH - 16);
    chk("R7 overflow cleared by start", 32'(overflow), 32'd0);
    stop();
    for (int i = 0; i < DEPTH; i++) pop_expect("R9 order", 32'hC000_0000 + 32'(i));
    chk("R7 dropped sample absent", 32'(rd_valid), 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    wait_neg(4);
    rst_n = 1'b1;
    wait_neg(1);
    t_reset();
    t_word32();
    t_trigger();
    t_pack16();
    t_pack8();
    t_stop_flush();
    t_ack_level();
    t_overflow();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule